// File: doc/BRIEF.md
# Thermal Event Threshold Comparator

This block sits behind a temperature sensor front end. Each time a new temperature sample arrives, the block judges it against three programmable limits: an upper alarm limit, a lower alarm limit and a critical limit. From that judgement and a 16-bit configuration word it drives a registered active-low event output, which is meant for an open-drain pad. Software programs the limits, the configuration and the sample resolution through a simple parallel write port. A combinational read port returns the stored values.

There are two ways to report an event. In comparator mode the output follows the present condition, and a selectable hysteresis is applied on release. In interrupt mode a window crossing is held until software clears it, while a critical excursion keeps the output asserted no matter what. Two sticky lock bits freeze the alarm window limits and the critical limit against later writes. A critical-only option makes the upper and lower crossings ignored.

Top module: `thermal_event_cmp`

## Requirements
- R1: After reset the configuration word reads 0 (comparator mode, output disabled), all three limits read 0, the resolution register (address 4) reads 1, and `event_n` is 1.
- R2: Samples are 13-bit signed values in 1/16 °C. On `sample_valid`, the sample is stored with its low (3 − res) bits forced to zero, where res is the 2-bit resolution code (0 = 0.5 °C, 1 = 0.25 °C, 2 = 0.125 °C, 3 = 0.0625 °C). The stored sample reads back sign-extended to 16 bits at address 5.
- R3: Writes to address 1 (upper), 2 (lower) or 3 (critical) take `wr_data[12:0]` as a signed 1/16 °C value with bits 1:0 forced to zero. The limit reads back sign-extended to 16 bits.
- R4: Configuration bit 6 (window lock) is set by writing 1 and is cleared only by reset. While it is set, writes to addresses 1 and 2 are ignored.
- R5: Configuration bit 7 (critical lock) is set by writing 1 and is cleared only by reset. While it is set, writes to address 3 are ignored. The window lock does not block address 3.
- R6: Comparator mode (bit 0 = 0). The upper flag sets when the sample is above upper. The lower flag sets when the sample is below lower. The critical flag sets when the sample is above critical. The event is active while any flag is set.
- R7: Bits 10:9 select a hysteresis of 0, 1.5, 3 or 6 °C (0, 24, 48, 96 sixteenths). The upper and critical flags clear once the sample is at or below the limit minus the hysteresis. The lower flag clears once the sample is at or above the limit plus the hysteresis. Between these points a flag holds.
- R8: Interrupt mode (bit 0 = 1). A sample that newly raises the combined window flag (upper or lower) latches the event. Writing configuration bit 5 as 1 clears the latch. Bit 5 reads back as 0.
- R9: In interrupt mode a set critical flag keeps the event active even after a clear.
- R10: Configuration bit 2 (critical-only) set: the upper and lower flags do not contribute to the event in either mode.
- R11: Configuration bit 3 enables the output: `event_n` is 0 only while the event is active and bit 3 is set. Configuration bit 4 reads back the event state whether or not the output is enabled.
- R12: A write and a sample in the same cycle are judged together, using the newly written values. `event_n` and all readback reflect them right after that clock edge. Reads of addresses 6 and 7 return 0, and writes to addresses 5 to 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_valid | input | 1 | New temperature sample present this cycle |
| sample | input | 13 | Signed temperature in 1/16 °C |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| event_n | output | 1 | Active-low event output |

## Verification
A flag or latch holding a wrong value shows on `event_n` one edge after the sample or write that should have changed it. It also shows in status bit 4 of the configuration readback, even when the output is disabled. The bench therefore compares `event_n` and one readback address after every cycle against a model. Because the hysteresis hold region keeps a flag set across several samples, an error in the hold logic can stay visible for many cycles, and the random samples are placed around the limits so that they land in that region. A lock that drops, or a limit that is wrongly overwritten, appears at once in the readback of the limit registers.

// File: rtl/thr_pkg.sv
package thr_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CFG  = 3'd0;
    localparam logic [ADDR_W-1:0] A_UP   = 3'd1;
    localparam logic [ADDR_W-1:0] A_LO   = 3'd2;
    localparam logic [ADDR_W-1:0] A_CR   = 3'd3;
    localparam logic [ADDR_W-1:0] A_RES  = 3'd4;
    localparam logic [ADDR_W-1:0] A_TEMP = 3'd5;

    // configuration bit positions
    localparam int B_MODE  = 0;
    localparam int B_CONLY = 2;
    localparam int B_EN    = 3;
    localparam int B_STAT  = 4;
    localparam int B_CLR   = 5;
    localparam int B_WLOCK = 6;
    localparam int B_CLOCK = 7;
    localparam int B_HYST  = 9;

    localparam logic [1:0] RES_RESET = 2'd1;

    typedef struct packed {
        logic [1:0] hyst;
        logic       clock;
        logic       wlock;
        logic       en;
        logic       conly;
        logic       mode;
    } cfg_t;
endpackage

// File: rtl/thr_regs.sv
module thr_regs
    import thr_pkg::*;
#(
    parameter int TEMP_W = 13,
    parameter int FRAC_W = 4,
    parameter int REG_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [REG_W-1:0]         wr_data,
    output cfg_t                     cfg_d,
    output cfg_t                     cfg_q,
    output logic signed [TEMP_W-1:0] up_d,
    output logic signed [TEMP_W-1:0] lo_d,
    output logic signed [TEMP_W-1:0] cr_d,
    output logic signed [TEMP_W-1:0] up_q,
    output logic signed [TEMP_W-1:0] lo_q,
    output logic signed [TEMP_W-1:0] cr_q,
    output logic [1:0]               res_d,
    output logic [1:0]               res_q,
    output logic                     clr_pulse
);
    localparam int GRAIN_Z = FRAC_W - 2;
    localparam logic [TEMP_W-1:0] LIM_MASK = {{(TEMP_W-GRAIN_Z){1'b1}}, {GRAIN_Z{1'b0}}};

    typedef struct packed {
        cfg_t                     cfg;
        logic signed [TEMP_W-1:0] up;
        logic signed [TEMP_W-1:0] lo;
        logic signed [TEMP_W-1:0] cr;
        logic [1:0]               res;
    } st_t;

    st_t s_d, s_q;
    logic [TEMP_W-1:0] lim_w;

    always_comb begin
        s_d       = s_q;
        clr_pulse = 1'b0;
        lim_w     = wr_data[TEMP_W-1:0] & LIM_MASK;
        if (wr_en) begin
            case (wr_addr)
                A_CFG: begin
                    s_d.cfg.mode  = wr_data[B_MODE];
                    s_d.cfg.conly = wr_data[B_CONLY];
                    s_d.cfg.en    = wr_data[B_EN];
                    s_d.cfg.wlock = s_q.cfg.wlock | wr_data[B_WLOCK];
                    s_d.cfg.clock = s_q.cfg.clock | wr_data[B_CLOCK];
                    s_d.cfg.hyst  = wr_data[B_HYST+1:B_HYST];
                    clr_pulse     = wr_data[B_CLR];
                end
                A_UP:  if (!s_q.cfg.wlock) s_d.up = $signed(lim_w);
                A_LO:  if (!s_q.cfg.wlock) s_d.lo = $signed(lim_w);
                A_CR:  if (!s_q.cfg.clock) s_d.cr = $signed(lim_w);
                A_RES: s_d.res = wr_data[1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.res <= RES_RESET;
        end else begin
            s_q <= s_d;
        end
    end

    assign cfg_d = s_d.cfg;
    assign cfg_q = s_q.cfg;
    assign up_d  = s_d.up;
    assign lo_d  = s_d.lo;
    assign cr_d  = s_d.cr;
    assign up_q  = s_q.up;
    assign lo_q  = s_q.lo;
    assign cr_q  = s_q.cr;
    assign res_d = s_d.res;
    assign res_q = s_q.res;
endmodule

// File: rtl/thr_hyst_flag.sv
module thr_hyst_flag #(
    parameter int EW    = 15,
    parameter bit ABOVE = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valid,
    input  logic signed [EW-1:0] temp,
    input  logic signed [EW-1:0] limit,
    input  logic signed [EW-1:0] hyst,
    output logic                 flag_d,
    output logic                 flag_q
);
    logic set_c, rel_c;

    generate
        if (ABOVE) begin : g_above
            always_comb begin
                set_c = temp > limit;
                rel_c = temp <= (limit - hyst);
            end
        end else begin : g_below
            always_comb begin
                set_c = temp < limit;
                rel_c = temp >= (limit + hyst);
            end
        end
    endgenerate

    always_comb begin
        flag_d = flag_q;
        if (valid) begin
            if (set_c)      flag_d = 1'b1;
            else if (rel_c) flag_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end
endmodule

// File: rtl/thr_event_ctrl.sv
module thr_event_ctrl
    import thr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cfg_t cfg_d,
    input  logic clr,
    input  logic hi_d,
    input  logic lo_d,
    input  logic cr_d,
    output logic active_q,
    output logic latch_q,
    output logic event_n
);
    typedef struct packed {
        logic win;
        logic latch;
        logic active;
        logic evn;
    } st_t;

    st_t s_d, s_q;
    logic rise;

    always_comb begin
        s_d     = s_q;
        s_d.win = hi_d | lo_d;
        rise    = s_d.win & ~s_q.win;
        if (cfg_d.mode) begin
            s_d.latch  = (s_q.latch & ~clr) | (rise & ~cfg_d.conly);
            s_d.active = s_d.latch | cr_d;
        end else begin
            s_d.latch  = 1'b0;
            s_d.active = cr_d | (~cfg_d.conly & s_d.win);
        end
        s_d.evn = ~(s_d.active & cfg_d.en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.evn <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign active_q = s_q.active;
    assign latch_q  = s_q.latch;
    assign event_n  = s_q.evn;
endmodule

// File: rtl/thermal_event_cmp.sv
module thermal_event_cmp
    import thr_pkg::*;
#(
    parameter int TEMP_W = 13,
    parameter int FRAC_W = 4,
    parameter int REG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_valid,
    input  logic [TEMP_W-1:0] sample,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    output logic              event_n
);
    localparam int EW = TEMP_W + 2;

    cfg_t cfg_d, cfg_q;
    logic signed [TEMP_W-1:0] up_d, lo_d, cr_d, up_q, lo_q, cr_q;
    logic [1:0] res_d, res_q;
    logic clr_pulse;

    thr_regs #(.TEMP_W(TEMP_W), .FRAC_W(FRAC_W), .REG_W(REG_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cfg_d(cfg_d), .cfg_q(cfg_q), .up_d(up_d), .lo_d(lo_d), .cr_d(cr_d),
        .up_q(up_q), .lo_q(lo_q), .cr_q(cr_q), .res_d(res_d), .res_q(res_q),
        .clr_pulse(clr_pulse)
    );

    // sample store with resolution masking
    typedef struct packed {
        logic signed [TEMP_W-1:0] temp;
    } ts_t;
    ts_t t_d, t_q;
    logic [TEMP_W-1:0] keep_mask;
    logic [TEMP_W-1:0] masked;

    always_comb begin
        keep_mask = ~((TEMP_W'(1) << (FRAC_W - 1 - int'(res_d))) - TEMP_W'(1));
        masked    = sample & keep_mask;
        t_d       = t_q;
        if (sample_valid) t_d.temp = $signed(masked);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    function automatic logic signed [EW-1:0] hyst_amt(input logic [1:0] sel);
        if (sel == 2'd0) return '0;
        return $signed(EW'(3) << (FRAC_W - 2 + int'(sel)));
    endfunction

    logic signed [EW-1:0] t_ext, up_ext, lo_ext, cr_ext, h_ext;
    assign t_ext  = EW'($signed(masked));
    assign up_ext = EW'(up_d);
    assign lo_ext = EW'(lo_d);
    assign cr_ext = EW'(cr_d);
    assign h_ext  = hyst_amt(cfg_d.hyst);

    logic hif_d, hif_q, lof_d, lof_q, crf_d, crf_q;

    thr_hyst_flag #(.EW(EW), .ABOVE(1'b1)) u_hi (
        .clk(clk), .rst_n(rst_n), .valid(sample_valid), .temp(t_ext),
        .limit(up_ext), .hyst(h_ext), .flag_d(hif_d), .flag_q(hif_q)
    );
    thr_hyst_flag #(.EW(EW), .ABOVE(1'b0)) u_lo (
        .clk(clk), .rst_n(rst_n), .valid(sample_valid), .temp(t_ext),
        .limit(lo_ext), .hyst(h_ext), .flag_d(lof_d), .flag_q(lof_q)
    );
    thr_hyst_flag #(.EW(EW), .ABOVE(1'b1)) u_cr (
        .clk(clk), .rst_n(rst_n), .valid(sample_valid), .temp(t_ext),
        .limit(cr_ext), .hyst(h_ext), .flag_d(crf_d), .flag_q(crf_q)
    );

    logic active_q, latch_q;

    thr_event_ctrl u_evt (
        .clk(clk), .rst_n(rst_n), .cfg_d(cfg_d), .clr(clr_pulse),
        .hi_d(hif_d), .lo_d(lof_d), .cr_d(crf_d),
        .active_q(active_q), .latch_q(latch_q), .event_n(event_n)
    );

    // readback
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CFG: begin
                rd_data[B_MODE]            = cfg_q.mode;
                rd_data[B_CONLY]           = cfg_q.conly;
                rd_data[B_EN]              = cfg_q.en;
                rd_data[B_STAT]            = active_q;
                rd_data[B_WLOCK]           = cfg_q.wlock;
                rd_data[B_CLOCK]           = cfg_q.clock;
                rd_data[B_HYST+1:B_HYST]   = cfg_q.hyst;
            end
            A_UP:   rd_data = REG_W'(up_q);
            A_LO:   rd_data = REG_W'(lo_q);
            A_CR:   rd_data = REG_W'(cr_q);
            A_RES:  rd_data = REG_W'(res_q);
            A_TEMP: rd_data = REG_W'(t_q.temp);
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/thermal_event_cmp_chk.sv
module thermal_event_cmp_chk
    import thr_pkg::*;
#(
    parameter int TEMP_W = 13,
    parameter int FRAC_W = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input cfg_t                     cfg_q,
    input logic signed [TEMP_W-1:0] up_q,
    input logic signed [TEMP_W-1:0] lo_q,
    input logic signed [TEMP_W-1:0] cr_q,
    input logic                     crf_q,
    input logic                     latch_q,
    input logic                     event_n
);
    localparam int GZ = FRAC_W - 2;

    p_event_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.en |-> event_n);

    p_crit_forces_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (crf_q && cfg_q.en) |-> !event_n);

    p_win_lock_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.wlock |=> ($stable(up_q) && $stable(lo_q)));

    p_win_lock_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.wlock |=> cfg_q.wlock);

    p_crit_lock_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.clock |=> ($stable(cr_q) && cfg_q.clock));

    p_limit_grain_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q[GZ-1:0] == '0) && (lo_q[GZ-1:0] == '0) && (cr_q[GZ-1:0] == '0));

    p_latch_only_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.mode |-> !latch_q);
endmodule

bind thermal_event_cmp thermal_event_cmp_chk #(.TEMP_W(TEMP_W), .FRAC_W(FRAC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_q(cfg_q), .up_q(up_q), .lo_q(lo_q), .cr_q(cr_q),
    .crf_q(crf_q), .latch_q(latch_q), .event_n(event_n)
);

// File: tb/sim_thermal_event_cmp.sv
module sim_thermal_event_cmp;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        sample_valid;
    logic [12:0] sample;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [15:0] wr_data;
    logic [2:0]  rd_addr;
    logic [15:0] rd_data;
    logic        event_n;

    always #4 clk = ~clk;

    thermal_event_cmp u0 (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .sample(sample),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .event_n(event_n)
    );

    int n_chk = 0;
    int n_err = 0;

    // model state
    bit m_mode, m_conly, m_en, m_wl, m_cl;
    int m_hyst, m_up, m_lo, m_cr, m_res, m_temp;
    bit m_hi, m_lf, m_cf, m_win, m_latch, m_active, m_evn;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    function automatic int sx13(input int d);
        int x = d & 'h1FFF;
        if (x >= 'h1000) x -= 'h2000;
        return x;
    endfunction

    function automatic int rd_model(input int a);
        int v;
        case (a)
            0: v = int'(m_mode) | (int'(m_conly) << 2) | (int'(m_en) << 3) |
                   (int'(m_active) << 4) | (int'(m_wl) << 6) | (int'(m_cl) << 7) | (m_hyst << 9);
            1: v = m_up & 'hFFFF;
            2: v = m_lo & 'hFFFF;
            3: v = m_cr & 'hFFFF;
            4: v = m_res;
            5: v = m_temp & 'hFFFF;
            default: v = 0;
        endcase
        return v;
    endfunction

    task automatic model_tick(input bit v, input int smp, input bit w, input int a, input int d);
        bit clr = 0;
        int t, h;
        bit nw, rise;
        if (w) begin
            case (a)
                0: begin
                    m_mode = d[0]; m_conly = d[2]; m_en = d[3];
                    m_wl = m_wl | d[6]; m_cl = m_cl | d[7];
                    m_hyst = (d >> 9) & 3; clr = d[5];
                end
                1: if (!m_wl) m_up = sx13(d) & ~3;
                2: if (!m_wl) m_lo = sx13(d) & ~3;
                3: if (!m_cl) m_cr = sx13(d) & ~3;
                4: m_res = d & 3;
                default: ;
            endcase
        end
        if (v) begin
            t = sx13(smp) & ~((1 << (3 - m_res)) - 1);
            m_temp = t;
            h = (m_hyst == 0) ? 0 : (3 << (2 + m_hyst));
            if (t > m_up) m_hi = 1; else if (t <= m_up - h) m_hi = 0;
            if (t < m_lo) m_lf = 1; else if (t >= m_lo + h) m_lf = 0;
            if (t > m_cr) m_cf = 1; else if (t <= m_cr - h) m_cf = 0;
        end
        nw = m_hi | m_lf;
        rise = nw & !m_win;
        m_win = nw;
        if (m_mode) begin
            m_latch = (m_latch & !clr) | (rise & !m_conly);
            m_active = m_latch | m_cf;
        end else begin
            m_latch = 0;
            m_active = m_cf | (!m_conly & nw);
        end
        m_evn = !(m_active & m_en);
    endtask

    // one clock of stimulus; compares event_n and one readback address with the model
    task automatic step(input string tag, input bit v, input int smp, input bit w,
                        input int a, input int d, input int ra);
        sample_valid = v; sample = 13'(smp);
        wr_en = w; wr_addr = 3'(a); wr_data = 16'(d);
        @(posedge clk);
        model_tick(v, smp, w, a, d);
        @(negedge clk);
        sample_valid = 0; wr_en = 0; rd_addr = 3'(ra);
        #1;
        chk(tag, int'(event_n), int'(m_evn));
        chk(tag, int'(rd_data), rd_model(ra));
    endtask

    task automatic rd_chk(input string tag, input int ra, input int exp);
        rd_addr = 3'(ra);
        #1;
        chk(tag, int'(rd_data), exp);
    endtask

    task automatic ev_chk(input string tag, input int exp);
        chk(tag, int'(event_n), exp);
    endtask

    initial begin
        #(8 * 200000);
        n_err++;
        $display("FAIL R12 watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20250611));
        m_res = 1;
        m_evn = 1;
        rst_n = 0; sample_valid = 0; sample = '0; wr_en = 0; wr_addr = '0;
        wr_data = '0; rd_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        ev_chk("R1 event_n after reset", 1);
        rd_chk("R1 config after reset", 0, 0);
        rd_chk("R1 upper after reset", 1, 0);
        rd_chk("R1 critical after reset", 3, 0);
        rd_chk("R1 resolution after reset", 4, 1);
        @(negedge clk);

        // random phase (locks never written here)
        for (int i = 0; i < 3000; i++) begin
            int a, d;
            bit w, v;
            v = 1'($urandom_range(0, 1));
            w = ($urandom_range(0, 3) == 0);
            a = $urandom_range(0, 7);
            case (a)
                0: d = int'($urandom & 32'hFF3F);
                1, 2, 3: d = $urandom_range(0, 1700) - 200;
                default: d = int'($urandom & 32'hFFFF);
            endcase
            step("R6 R7 R8 random vs model", v, $urandom_range(0, 1900) - 300, w, a, d,
                 $urandom_range(0, 7));
        end

        // directed setup
        step("R2 res write", 0, 0, 1, 4, 1, 4);
        step("R3 upper write", 0, 0, 1, 1, 'h0283, 1);
        rd_chk("R3 upper grain", 1, 640);
        step("R3 lower negative", 0, 0, 1, 2, 'h1FF1, 2);
        rd_chk("R3 lower sign extend", 2, 'hFFF0);
        step("R3 lower write", 0, 0, 1, 2, 160, 2);
        step("R3 crit write", 0, 0, 1, 3, 1280, 3);
        rd_chk("R3 crit readback", 3, 1280);
        step("R6 cfg comparator", 0, 0, 1, 0, 'h0008, 0);

        // R6 comparator
        step("R6 above upper", 1, 800, 0, 0, 0, 5);
        ev_chk("R6 above upper asserts", 0);
        step("R6 equal upper", 1, 640, 0, 0, 0, 5);
        ev_chk("R6 equal upper releases", 1);
        step("R6 below lower", 1, 159, 0, 0, 0, 5);
        ev_chk("R6 below lower asserts", 0);
        rd_chk("R2 masked 10-bit", 5, 156);
        step("R6 inside", 1, 400, 0, 0, 0, 0);
        ev_chk("R6 inside window", 1);

        // R7 hysteresis 1.5 C
        step("R7 cfg hyst", 0, 0, 1, 0, 'h0208, 0);
        step("R7 above", 1, 656, 0, 0, 0, 0);
        ev_chk("R7 above asserts", 0);
        step("R7 hold", 1, 624, 0, 0, 0, 0);
        ev_chk("R7 inside band holds", 0);
        step("R7 release", 1, 616, 0, 0, 0, 0);
        ev_chk("R7 limit minus hyst releases", 1);

        // R8 interrupt latch
        step("R8 cfg irq", 0, 0, 1, 0, 'h0209, 0);
        step("R8 crossing", 1, 700, 0, 0, 0, 0);
        ev_chk("R8 crossing latches", 0);
        step("R8 back inside", 1, 400, 0, 0, 0, 0);
        ev_chk("R8 latch holds", 0);
        step("R8 clear", 0, 0, 1, 0, 'h0229, 0);
        ev_chk("R8 clear releases", 1);
        rd_chk("R8 clear bit reads 0", 0, 'h0209);

        // R9 critical in interrupt mode
        step("R9 critical", 1, 1300, 0, 0, 0, 0);
        ev_chk("R9 critical asserts", 0);
        step("R9 clear attempt", 0, 0, 1, 0, 'h0229, 0);
        ev_chk("R9 critical survives clear", 0);
        step("R9 cool", 1, 400, 0, 0, 0, 0);
        ev_chk("R9 cooled releases", 1);

        // R10 critical only
        step("R10 cfg", 0, 0, 1, 0, 'h020C, 0);
        step("R10 above upper", 1, 700, 0, 0, 0, 0);
        ev_chk("R10 upper suppressed", 1);
        step("R10 critical", 1, 1300, 0, 0, 0, 0);
        ev_chk("R10 critical asserts", 0);
        step("R10 cool", 1, 400, 0, 0, 0, 0);

        // R11 enable and status
        step("R11 disable", 0, 0, 1, 0, 'h0204, 0);
        step("R11 critical disabled", 1, 1300, 0, 0, 0, 0);
        ev_chk("R11 output gated", 1);
        rd_chk("R11 status bit set", 0, 'h0214);
        step("R12 enable same edge", 0, 0, 1, 0, 'h020C, 0);
        ev_chk("R12 enable takes effect next edge", 0);
        step("R11 cool", 1, 400, 0, 0, 0, 0);
        step("R12 write addr5 ignored", 0, 0, 1, 5, 'h1234, 5);
        rd_chk("R12 addr6 reads 0", 6, 0);

        // R2 resolution
        step("R2 res 9", 0, 0, 1, 4, 0, 4);
        step("R2 sample", 1, 23, 0, 0, 0, 5);
        rd_chk("R2 9-bit mask", 5, 16);
        step("R2 res 12", 0, 0, 1, 4, 3, 4);
        step("R2 sample", 1, 23, 0, 0, 0, 5);
        rd_chk("R2 12-bit keeps all", 5, 23);
        step("R2 res 10", 0, 0, 1, 4, 1, 4);
        step("R2 negative", 1, -5, 0, 0, 0, 5);
        rd_chk("R2 negative mask", 5, 'hFFF8);

        // R4 / R5 locks
        step("R4 set window lock", 0, 0, 1, 0, 'h0048, 0);
        step("R4 upper blocked", 0, 0, 1, 1, 'h0100, 1);
        rd_chk("R4 upper unchanged", 1, 640);
        step("R4 lower blocked", 0, 0, 1, 2, 'h0010, 2);
        rd_chk("R4 lower unchanged", 2, 160);
        step("R4 unlock attempt", 0, 0, 1, 0, 'h0008, 0);
        rd_addr = 3'd0; #1;
        chk("R4 lock sticky", int'(rd_data[6]), 1);
        step("R5 crit not window locked", 0, 0, 1, 3, 1200, 3);
        rd_chk("R5 crit writable", 3, 1200);
        step("R5 set crit lock", 0, 0, 1, 0, 'h0088, 0);
        step("R5 crit blocked", 0, 0, 1, 3, 1000, 3);
        rd_chk("R5 crit unchanged", 3, 1200);

        summary();
        $finish;
    end
endmodule